// File: doc/BRIEF.md
# Host-to-Slave Mailbox with Shared Status Byte

This block is a byte-wide mailbox between an external host bus and an internal slave processor bus. The host writes bytes into an inbound register, and the slave reads them out. The slave writes bytes into an outbound register, and the host reads them out. Both sides can see an 8-bit status byte. The status byte holds two buffer-full flags, a command/data marker, and five general-purpose bits that the slave owns.

Each host write also samples the host address line A0 into the status byte. Slave firmware therefore knows whether the byte just received is a command or data. When the inbound buffer holds an unread byte, the slave receives a level interrupt, gated by an enable bit that the slave controls. All accesses are single-cycle strobes on one clock. A host read with A0 low returns the outbound byte; with A0 high it returns the status byte. A host write with either A0 value goes to the inbound register.

Top module: `kbc_mailbox`

## Requirements
- R1: On reset (`rst`), or in any cycle with `stby` high, the status byte becomes 0x00 at the next clock edge.
- R2: A host write stores `host_wdata` in the inbound register. It sets status bit 1 (inbound full) and loads status bit 3 with `host_a0` (1 = command, 0 = data).
- R3: A slave read at `slv_addr`=0 returns the inbound byte and clears status bit 1.
- R4: When a host write and a slave inbound read fall in the same cycle, the slave gets the old byte, the new byte is stored, and status bit 1 ends at 1.
- R5: A slave write at `slv_addr`=1 loads status bits 7..4 and 2 (mask 0xF4) from `slv_wdata`. It leaves bits 3 and 1 unchanged. The host cannot change these bits.
- R6: A slave write at `slv_addr`=0 stores the outbound byte and sets status bit 0 (outbound full). A host read with `host_a0`=0 returns the outbound byte and clears bit 0.
- R7: A slave status write with `slv_wdata[0]`=0 clears status bit 0. With `slv_wdata[0]`=1 it leaves bit 0 unchanged.
- R8: A host read with `host_a0`=1 returns the status byte and changes no state.
- R9: `slv_irq` equals status bit 1 AND the interrupt enable. The enable is bit 0 of the slave register at `slv_addr`=2. Reading that address returns the enable in bit 0.
- R10: When a slave outbound write and a host outbound read fall in the same cycle, the host gets the old byte and status bit 0 ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby | input | 1 | Hardware standby; clears the status byte |
| host_wr | input | 1 | Host write strobe (to inbound register) |
| host_rd | input | 1 | Host read strobe |
| host_a0 | input | 1 | Host address bit: read select, command/data marker on writes |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (valid in the strobe cycle) |
| slv_wr | input | 1 | Slave write strobe |
| slv_rd | input | 1 | Slave read strobe |
| slv_addr | input | 2 | Slave register select: 0 data, 1 status, 2 control |
| slv_wdata | input | 8 | Slave write byte |
| slv_rdata | output | 8 | Slave read byte (valid in the strobe cycle) |
| slv_irq | output | 1 | Level interrupt to the slave |

## Verification
Two pairs of functions can collide on one clock edge. One pair is a host write with a slave inbound read, which sets and clears the inbound flag. The other is a slave outbound write with a host outbound read, which sets and clears the outbound flag. The bench drives each pair in a single strobe cycle. In both cases it checks that the reader gets the old byte. It then reads the status byte back and judges the flag against a behavioural model in which the set wins. The interrupt level is compared with the model on every clock.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int STAT_W = 8;
  localparam int CD_BIT  = 3;
  localparam int IBF_BIT = 1;
  localparam int OBF_BIT = 0;
  localparam logic [STAT_W-1:0] USER_MASK = 8'hF4;

  typedef enum logic [1:0] {
    SLV_DATA = 2'd0,
    SLV_STAT = 2'd1,
    SLV_CTRL = 2'd2
  } slv_sel_e;
endpackage

// File: rtl/kbc_data_regs.sv
module kbc_data_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_load,
  input  logic [DATA_W-1:0] in_din,
  input  logic              out_load,
  input  logic [DATA_W-1:0] out_din,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (in_load)  in_q  <= in_din;
      if (out_load) out_q <= out_din;
    end
  end
endmodule

// File: rtl/kbc_status_reg.sv
module kbc_status_reg
  import kbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stby,
  input  logic              host_in_wr,
  input  logic              host_a0,
  input  logic              host_out_rd,
  input  logic              slv_in_rd,
  input  logic              slv_out_wr,
  input  logic              slv_stat_wr,
  input  logic [STAT_W-1:0] slv_wdata,
  output logic [STAT_W-1:0] stat_d,
  output logic [STAT_W-1:0] stat_q
);
  always_comb begin
    stat_d = stat_q;
    if (slv_stat_wr) begin
      stat_d = (stat_q & ~USER_MASK) | (slv_wdata & USER_MASK);
      if (!slv_wdata[OBF_BIT]) stat_d[OBF_BIT] = 1'b0;
    end
    if (host_out_rd) stat_d[OBF_BIT] = 1'b0;
    if (slv_out_wr)  stat_d[OBF_BIT] = 1'b1;
    if (slv_in_rd)   stat_d[IBF_BIT] = 1'b0;
    if (host_in_wr) begin
      stat_d[IBF_BIT] = 1'b1;
      stat_d[CD_BIT]  = host_a0;
    end
    if (rst || stby) stat_d = '0;
  end

  always_ff @(posedge clk) stat_q <= stat_d;
endmodule

// File: rtl/kbc_irq_ctrl.sv
module kbc_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ien_wr,
  input  logic ien_din,
  input  logic ibf_d,
  output logic ien_q,
  output logic irq
);
  logic ien_d;
  assign ien_d = ien_wr ? ien_din : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      ien_q <= ien_d;
      irq   <= ien_d & ibf_d;
    end
  end
endmodule

// File: rtl/kbc_mailbox.sv
module kbc_mailbox
  import kbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stby,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_a0,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              slv_wr,
  input  logic              slv_rd,
  input  logic [1:0]        slv_addr,
  input  logic [DATA_W-1:0] slv_wdata,
  output logic [DATA_W-1:0] slv_rdata,
  output logic              slv_irq
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] stat_d, stat_q;
  logic [DATA_W-1:0] in_q, out_q;
  logic              ien_q;
  logic              host_out_rd, slv_in_rd, slv_out_wr, slv_stat_wr, slv_ctrl_wr;

  assign host_out_rd = host_rd && !host_a0;
  assign slv_in_rd   = slv_rd && (slv_addr == SLV_DATA);
  assign slv_out_wr  = slv_wr && (slv_addr == SLV_DATA);
  assign slv_stat_wr = slv_wr && (slv_addr == SLV_STAT);
  assign slv_ctrl_wr = slv_wr && (slv_addr == SLV_CTRL);

  kbc_data_regs #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst),
    .in_load(host_wr), .in_din(host_wdata),
    .out_load(slv_out_wr), .out_din(slv_wdata),
    .in_q(in_q), .out_q(out_q)
  );

  kbc_status_reg u_stat (
    .clk(clk), .rst(rst), .stby(stby),
    .host_in_wr(host_wr), .host_a0(host_a0), .host_out_rd(host_out_rd),
    .slv_in_rd(slv_in_rd), .slv_out_wr(slv_out_wr), .slv_stat_wr(slv_stat_wr),
    .slv_wdata(slv_wdata[STAT_W-1:0]),
    .stat_d(stat_d), .stat_q(stat_q)
  );

  kbc_irq_ctrl u_irq (
    .clk(clk), .rst(rst),
    .ien_wr(slv_ctrl_wr), .ien_din(slv_wdata[0]),
    .ibf_d(stat_d[IBF_BIT]),
    .ien_q(ien_q), .irq(slv_irq)
  );

  logic [DATA_W-1:0] stat_ext, ctrl_ext;
  generate
    if (PAD_W > 0) begin : g_pad
      assign stat_ext = {{PAD_W{1'b0}}, stat_q};
    end else begin : g_nopad
      assign stat_ext = stat_q[DATA_W-1:0];
    end
  endgenerate
  assign ctrl_ext = {{(DATA_W-1){1'b0}}, ien_q};

  assign host_rdata = host_a0 ? stat_ext : out_q;

  always_comb begin
    case (slv_addr)
      SLV_DATA: slv_rdata = in_q;
      SLV_STAT: slv_rdata = stat_ext;
      SLV_CTRL: slv_rdata = ctrl_ext;
      default:  slv_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kbc_mailbox_chk.sv
module kbc_mailbox_chk (
  input logic       clk,
  input logic       rst,
  input logic       stby,
  input logic       host_wr,
  input logic       host_rd,
  input logic       host_a0,
  input logic [7:0] host_rdata,
  input logic       slv_wr,
  input logic       slv_rd,
  input logic [1:0] slv_addr,
  input logic [7:0] slv_wdata,
  input logic       slv_irq,
  input logic [7:0] stat_q,
  input logic       ien_q
);
  assert_stat_clear_R1: assert property (@(posedge clk)
    (rst || stby) |=> stat_q == 8'h00);

  assert_host_write_R2: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !stby) |=> (stat_q[1] && stat_q[3] == $past(host_a0)));

  assert_in_read_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (slv_rd && slv_addr == 2'd0 && !host_wr && !stby) |=> !stat_q[1]);

  assert_in_collide_R4: assert property (@(posedge clk) disable iff (rst)
    (host_wr && slv_rd && slv_addr == 2'd0 && !stby) |=> stat_q[1]);

  assert_user_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (slv_wr && slv_addr == 2'd1 && !host_wr && !slv_rd && !stby) |=>
      ((stat_q & 8'hF4) == ($past(slv_wdata) & 8'hF4) &&
       stat_q[3] == $past(stat_q[3]) && stat_q[1] == $past(stat_q[1])));

  assert_out_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !host_a0 && !slv_wr && !stby) |=> !stat_q[0]);

  assert_obf_one_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (slv_wr && slv_addr == 2'd1 && slv_wdata[0] && !host_rd && !stby) |=>
      stat_q[0] == $past(stat_q[0]));

  assert_status_read_R8: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_a0) |-> host_rdata == stat_q);

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    slv_irq == (stat_q[1] && ien_q));

  assert_out_collide_R10: assert property (@(posedge clk) disable iff (rst)
    (slv_wr && slv_addr == 2'd0 && !stby) |=> stat_q[0]);
endmodule

bind kbc_mailbox kbc_mailbox_chk u_chk (
  .clk(clk), .rst(rst), .stby(stby),
  .host_wr(host_wr), .host_rd(host_rd), .host_a0(host_a0),
  .host_rdata(host_rdata),
  .slv_wr(slv_wr), .slv_rd(slv_rd), .slv_addr(slv_addr),
  .slv_wdata(slv_wdata), .slv_irq(slv_irq),
  .stat_q(stat_q), .ien_q(ien_q)
);

// File: tb/kbc_mailbox_tb.sv
module kbc_mailbox_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stby = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_a0 = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       slv_wr = 1'b0, slv_rd = 1'b0;
  logic [1:0] slv_addr = '0;
  logic [7:0] slv_wdata = '0, slv_rdata;
  logic       slv_irq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_in = 0, m_out = 0, m_stat = 0;
  logic       m_ien = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_mailbox u_dut (
    .clk(clk), .rst(rst), .stby(stby),
    .host_wr(host_wr), .host_rd(host_rd), .host_a0(host_a0),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slv_wr(slv_wr), .slv_rd(slv_rd), .slv_addr(slv_addr),
    .slv_wdata(slv_wdata), .slv_rdata(slv_rdata), .slv_irq(slv_irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one clock: drive, check reads, model the edge, check irq
  task automatic cyc(input logic hw, input logic hr, input logic a0, input logic [7:0] hwd,
                     input logic sw, input logic sr, input logic [1:0] sa,
                     input logic [7:0] swd, input logic st, input string tag);
    logic [7:0] nx;
    @(negedge clk);
    host_wr = hw; host_rd = hr; host_a0 = a0; host_wdata = hwd;
    slv_wr = sw; slv_rd = sr; slv_addr = sa; slv_wdata = swd; stby = st;
    #1;
    if (hr) check(tag, host_rdata, a0 ? m_stat : m_out);
    if (sr) check(tag, slv_rdata, sa == 2'd0 ? m_in : sa == 2'd1 ? m_stat :
                                  sa == 2'd2 ? {7'd0, m_ien} : 8'h00);
    @(posedge clk);
    nx = m_stat;
    if (sw && sa == 2'd1) begin
      nx = (m_stat & 8'h0B) | (swd & 8'hF4);
      if (!swd[0]) nx[0] = 1'b0;
    end
    if (hr && !a0) nx[0] = 1'b0;
    if (sw && sa == 2'd0) begin nx[0] = 1'b1; m_out = swd; end
    if (sr && sa == 2'd0) nx[1] = 1'b0;
    if (hw) begin nx[1] = 1'b1; nx[3] = a0; m_in = hwd; end
    if (sw && sa == 2'd2) m_ien = swd[0];
    if (st) nx = 8'h00;
    m_stat = nx;
    m_irq = m_stat[1] & m_ien;
    #1;
    check("R9 irq", {7'd0, slv_irq}, {7'd0, m_irq});
  endtask

  task automatic idle();
    cyc(0,0,0,0, 0,0,0,0, 0, "idle");
  endtask
  task automatic stat_rd(input string tag);
    cyc(0,0,0,0, 0,1,2'd1,0, 0, tag);
  endtask
  task automatic host_stat_rd(input string tag);
    cyc(0,1,1,0, 0,0,0,0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    stat_rd("R1 reset status");
    host_stat_rd("R1 reset host view");

    // R2 data write, then R3 slave read
    cyc(1,0,0,8'h5A, 0,0,0,0, 0, "R2");
    stat_rd("R2 data marker");
    host_stat_rd("R8 host status read");
    stat_rd("R8 no side effect");
    cyc(0,0,0,0, 0,1,2'd0,0, 0, "R3 inbound byte");
    stat_rd("R3 flag cleared");

    // R2 command write
    cyc(1,0,1,8'hD1, 0,0,0,0, 0, "R2");
    stat_rd("R2 command marker");

    // R9 enable irq and toggle
    cyc(0,0,0,0, 1,0,2'd2,8'h01, 0, "R9");
    cyc(0,0,0,0, 0,1,2'd2,0, 0, "R9 enable readback");
    idle();

    // R4 collision
    cyc(1,0,0,8'h33, 0,1,2'd0,0, 0, "R4 old byte");
    stat_rd("R4 flag kept");
    cyc(0,0,0,0, 0,1,2'd0,0, 0, "R4 new byte");
    stat_rd("R3 cleared after");

    // R5 user bits
    cyc(0,0,0,0, 1,0,2'd1,8'hFF, 0, "R5");
    stat_rd("R5 user bits set");
    host_stat_rd("R5 host view");
    cyc(1,0,1,8'h00, 0,0,0,0, 0, "R5");
    stat_rd("R5 host write leaves user bits");
    cyc(0,0,0,0, 0,1,2'd0,0, 0, "R3");
    cyc(0,0,0,0, 1,0,2'd1,8'h50, 0, "R5");
    stat_rd("R5 partial pattern");

    // R6 outbound path
    cyc(0,0,0,0, 1,0,2'd0,8'h77, 0, "R6");
    stat_rd("R6 outbound full");
    cyc(0,1,0,0, 0,0,0,0, 0, "R6 outbound byte");
    stat_rd("R6 outbound cleared");

    // R7 clear by status write
    cyc(0,0,0,0, 1,0,2'd0,8'h99, 0, "R6");
    cyc(0,0,0,0, 1,0,2'd1,8'hF5, 0, "R7");
    stat_rd("R7 write one ignored");
    cyc(0,0,0,0, 1,0,2'd1,8'h00, 0, "R7");
    stat_rd("R7 write zero clears");

    // R10 outbound collision
    cyc(0,1,0,0, 1,0,2'd0,8'h88, 0, "R10 old byte");
    stat_rd("R10 flag kept");
    cyc(0,1,0,0, 0,0,0,0, 0, "R10 new byte");

    // patterns: alternating host writes and slave reads
    for (int i = 0; i < 8; i++) begin
      cyc(1,0,i[0],8'(i*37+3), 0,0,0,0, 0, "R2");
      stat_rd("R2 pattern");
      cyc(0,0,0,0, 0,1,2'd0,0, 0, "R3 pattern");
    end

    // R1 standby
    cyc(1,0,1,8'h12, 1,0,2'd1,8'hF4, 0, "R1");
    cyc(0,0,0,0, 1,0,2'd0,8'h21, 0, "R1");
    cyc(0,0,0,0, 0,0,0,0, 1, "R1");
    stat_rd("R1 standby clear");
    host_stat_rd("R1 standby host view");

    idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule